// File: doc/BRIEF.md
# UART Receive Address Recognition Filter

This block sits behind a UART receiver that has already deserialised a frame. On every frame-complete strobe it decides whether the frame may be handed to software. If it may, the block sets a receive-ready flag and holds the byte and the ninth bit. If it may not, the frame is dropped with no visible trace. It also keeps a sticky framing-error flag.

In the 9-bit modes with multiprocessor filtering on, only frames whose ninth bit is 1 are considered. Such a frame is kept when its byte matches either of two addresses:
- the station's own address, where a cleared mask bit makes that bit position don't-care;
- a broadcast address, built from the OR of the address and mask registers.

With this, one station, a group of stations or all stations can be reached, with no software work on frames that are not theirs.

The framing-error flag can be read through a shared control bit position. A view-select input picks whether that position shows the error flag or the upper mode bit.

Top module: `uart_addr_filter`

## Requirements
- R1: After synchronous reset, rx_flag, fe_flag, rx_data and rx_bit9 are 0. The address and mask registers are 00h, so every address frame is accepted.
- R2: In mode 0 (rx_mode=00, shift register), every frame is accepted whatever mp_en, the address and the ninth bit are. rx_bit9 keeps its value, and fe_flag is never set.
- R3: In mode 1 (rx_mode=01) with mp_en=0, every frame is accepted. rx_bit9 receives the stop-bit value.
- R4: In mode 1 with mp_en=1, a frame is accepted only when frm_stop=1.
- R5: In modes 2 and 3 (rx_mode=10, 11) with mp_en=0, every frame is accepted, and frm_bit9 is captured into rx_bit9.
- R6: In modes 2 and 3 with mp_en=1, a frame is accepted only when frm_bit9=1 and the byte matches the given or the broadcast address.
- R7: The given address matches when (frm_data AND mask) equals (address AND mask).
- R8: The broadcast value B is address OR mask. It matches when every bit set in B is also set in frm_data.
- R9: While rx_flag is set and rf_clr is low, an arriving frame is dropped, and rx_data and rx_bit9 stay unchanged. When rf_clr is high in the same cycle as frm_done, the frame is judged as if the flag were clear.
- R10: In modes 1 to 3, frm_done with frm_stop=0 sets fe_flag, even when the frame itself is dropped. fe_flag stays set until fe_clr. If fe_clr coincides with a new error, the flag is set.
- R11: mode_hi_view equals fe_flag when fe_view=1, and rx_mode[1] otherwise, combinationally.
- R12: A write with addr_we or mask_we loads wr_data into that register. A frame in any later cycle uses the new value.
- R13: An accepted frame shows on rx_flag, rx_data and rx_bit9 in the cycle after the clock edge at which frm_done is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_done | input | 1 | One-cycle strobe: a frame has been received |
| frm_data | input | 8 | Received byte |
| frm_bit9 | input | 1 | Received ninth bit |
| frm_stop | input | 1 | Sampled stop bit (1 = valid) |
| rx_mode | input | 2 | Serial mode 0..3 |
| mp_en | input | 1 | Multiprocessor filtering enable |
| addr_we | input | 1 | Load the address register from wr_data |
| mask_we | input | 1 | Load the mask register from wr_data |
| wr_data | input | 8 | Register write data |
| rf_clr | input | 1 | Clear rx_flag |
| fe_clr | input | 1 | Clear fe_flag |
| fe_view | input | 1 | Select what the shared bit position shows |
| rx_flag | output | 1 | Receive-ready flag |
| rx_data | output | 8 | Held byte |
| rx_bit9 | output | 1 | Held ninth bit, or the stop bit in mode 1 |
| fe_flag | output | 1 | Sticky framing-error flag |
| mode_hi_view | output | 1 | Shared bit: fe_flag or rx_mode[1] |

## Verification
The assertions take for granted that frm_done is a single-cycle strobe. They also assume that rx_mode and mp_en are steady in the cycle a frame is judged, so that a decision made at one edge can be checked against the inputs seen at that edge. The stimulus changes mode, enable and frame fields only on the falling edge, and it raises frm_done for exactly one cycle per frame. Register writes and clears are issued in cycles of their own, except where a same-cycle clear is the point of the case (R9, R10).

// File: rtl/uart_af_pkg.sv
package uart_af_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        MODE_SHIFT  = 2'b00,
        MODE_8BIT   = 2'b01,
        MODE_9BIT_F = 2'b10,
        MODE_9BIT_V = 2'b11
    } rx_mode_e;

    typedef struct packed {
        byte_t data;
        logic  bit9;
        logic  stop;
    } rx_frame_t;

    typedef struct packed {
        logic  flag;
        byte_t data;
        logic  bit9;
        logic  fe;
    } rx_status_t;

    function automatic logic mode_is_9bit(rx_mode_e m);
        return (m == MODE_9BIT_F) || (m == MODE_9BIT_V);
    endfunction

    function automatic logic mode_has_stop(rx_mode_e m);
        return m != MODE_SHIFT;
    endfunction

endpackage

// File: rtl/uart_af_addr_regs.sv
module uart_af_addr_regs
    import uart_af_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  addr_we,
    input  logic  mask_we,
    input  byte_t wr_data,
    output byte_t addr_q,
    output byte_t mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            mask_q <= '0;
        end else begin
            if (addr_we) addr_q <= wr_data;
            if (mask_we) mask_q <= wr_data;
        end
    end

endmodule

// File: rtl/uart_af_accept.sv
module uart_af_accept
    import uart_af_pkg::*;
(
    input  rx_frame_t frame,
    input  rx_mode_e  mode,
    input  logic      mp_en,
    input  byte_t     addr_q,
    input  byte_t     mask_q,
    output logic      accept,
    output logic      stop_bad
);

    logic [BYTE_W-1:0] given_ok;
    logic [BYTE_W-1:0] bcast_ok;
    byte_t             bcast_val;

    assign bcast_val = addr_q | mask_q;

    // per-bit comparators: masked-off bits and zero broadcast bits always pass
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign given_ok[i] = !mask_q[i] || (frame.data[i] == addr_q[i]);
        assign bcast_ok[i] = !bcast_val[i] || frame.data[i];
    end

    logic addr_hit;
    assign addr_hit = (&given_ok) || (&bcast_ok);

    always_comb begin
        unique case (mode)
            MODE_SHIFT:  accept = 1'b1;
            MODE_8BIT:   accept = !mp_en || frame.stop;
            default:     accept = !mp_en || (frame.bit9 && addr_hit);
        endcase
    end

    assign stop_bad = mode_has_stop(mode) && !frame.stop;

endmodule

// File: rtl/uart_af_status.sv
module uart_af_status
    import uart_af_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frm_done,
    input  rx_frame_t  frame,
    input  rx_mode_e   mode,
    input  logic       accept,
    input  logic       stop_bad,
    input  logic       rf_clr,
    input  logic       fe_clr,
    output rx_status_t st
);

    logic pending;
    logic take;

    assign pending = st.flag && !rf_clr;
    assign take    = frm_done && accept && !pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (fe_clr) st.fe <= 1'b0;
            if (frm_done && stop_bad) st.fe <= 1'b1;
            if (rf_clr) st.flag <= 1'b0;
            if (take) begin
                st.flag <= 1'b1;
                st.data <= frame.data;
                if (mode_is_9bit(mode))
                    st.bit9 <= frame.bit9;
                else if (mode == MODE_8BIT)
                    st.bit9 <= frame.stop;
            end
        end
    end

    // R9: held frame is frozen while pending
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (st.flag && !rf_clr) |=> (st.flag && $stable(st.data) && $stable(st.bit9)));

    // R10: error flag is sticky until cleared
    assert_fe_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (st.fe && !fe_clr) |=> st.fe);

    // R2: shift mode never raises the error flag
    assert_fe_shift_R2: assert property (@(posedge clk) disable iff (rst)
        (frm_done && mode == MODE_SHIFT && !st.fe) |=> !st.fe);

endmodule

// File: rtl/uart_addr_filter.sv
module uart_addr_filter
    import uart_af_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frm_done,
    input  logic [7:0] frm_data,
    input  logic       frm_bit9,
    input  logic       frm_stop,
    input  logic [1:0] rx_mode,
    input  logic       mp_en,
    input  logic       addr_we,
    input  logic       mask_we,
    input  logic [7:0] wr_data,
    input  logic       rf_clr,
    input  logic       fe_clr,
    input  logic       fe_view,
    output logic       rx_flag,
    output logic [7:0] rx_data,
    output logic       rx_bit9,
    output logic       fe_flag,
    output logic       mode_hi_view
);

    rx_mode_e   mode;
    rx_frame_t  frame;
    byte_t      addr_q, mask_q;
    logic       accept, stop_bad;
    rx_status_t st;

    assign mode  = rx_mode_e'(rx_mode);
    assign frame = '{data: frm_data, bit9: frm_bit9, stop: frm_stop};

    uart_af_addr_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr_we (addr_we),
        .mask_we (mask_we),
        .wr_data (wr_data),
        .addr_q  (addr_q),
        .mask_q  (mask_q)
    );

    uart_af_accept u_acc (
        .frame    (frame),
        .mode     (mode),
        .mp_en    (mp_en),
        .addr_q   (addr_q),
        .mask_q   (mask_q),
        .accept   (accept),
        .stop_bad (stop_bad)
    );

    uart_af_status u_st (
        .clk      (clk),
        .rst      (rst),
        .frm_done (frm_done),
        .frame    (frame),
        .mode     (mode),
        .accept   (accept),
        .stop_bad (stop_bad),
        .rf_clr   (rf_clr),
        .fe_clr   (fe_clr),
        .st       (st)
    );

    assign rx_flag      = st.flag;
    assign rx_data      = st.data;
    assign rx_bit9      = st.bit9;
    assign fe_flag      = st.fe;
    assign mode_hi_view = fe_view ? st.fe : rx_mode[1];

    // R2: shift-mode frame always lands when nothing is pending
    assert_shift_take_R2: assert property (@(posedge clk) disable iff (rst)
        (frm_done && rx_mode == 2'b00 && !rx_flag) |=> (rx_flag && rx_data == $past(frm_data)));

    // R4: mode 1 filtering drops frames with a bad stop bit
    assert_m1_stop_R4: assert property (@(posedge clk) disable iff (rst)
        (frm_done && rx_mode == 2'b01 && mp_en && !frm_stop && !rx_flag) |=> !rx_flag);

    // R6: 9-bit filtering drops data frames (ninth bit 0)
    assert_mp_data_R6: assert property (@(posedge clk) disable iff (rst)
        (frm_done && rx_mode[1] && mp_en && !frm_bit9 && !rx_flag) |=> !rx_flag);

    // R10: bad stop in a framed mode raises the error flag
    assert_fe_set_R10: assert property (@(posedge clk) disable iff (rst)
        (frm_done && rx_mode != 2'b00 && !frm_stop) |=> fe_flag);

endmodule

// File: tb/tb_uart_addr_filter.sv
module tb_uart_addr_filter;

    logic       clk = 1'b0;
    logic       rst;
    logic       frm_done = 1'b0;
    logic [7:0] frm_data = '0;
    logic       frm_bit9 = 1'b0;
    logic       frm_stop = 1'b1;
    logic [1:0] rx_mode = 2'b00;
    logic       mp_en = 1'b0;
    logic       addr_we = 1'b0;
    logic       mask_we = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rf_clr = 1'b0;
    logic       fe_clr = 1'b0;
    logic       fe_view = 1'b0;
    logic       rx_flag;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       fe_flag;
    logic       mode_hi_view;

    always #2.5 clk = ~clk;

    uart_addr_filter dut (
        .clk(clk), .rst(rst), .frm_done(frm_done), .frm_data(frm_data),
        .frm_bit9(frm_bit9), .frm_stop(frm_stop), .rx_mode(rx_mode), .mp_en(mp_en),
        .addr_we(addr_we), .mask_we(mask_we), .wr_data(wr_data), .rf_clr(rf_clr),
        .fe_clr(fe_clr), .fe_view(fe_view), .rx_flag(rx_flag), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .fe_flag(fe_flag), .mode_hi_view(mode_hi_view)
    );

    typedef struct {
        logic       flag;
        logic [7:0] data;
        logic       bit9;
        logic       fe;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event ev_chk;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    // reference state, built from the requirements
    logic       m_flag = 0, m_b9 = 0, m_fe = 0;
    logic [7:0] m_data = '0, m_addr = '0, m_mask = '0;

    task automatic chk(string tag, string what, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // monitor: pops expected items and compares against outputs
    initial begin
        forever begin
            @(ev_chk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "rx_flag", int'(rx_flag), int'(e.flag));
                chk(e.tag, "rx_data", int'(rx_data), int'(e.data));
                chk(e.tag, "rx_bit9", int'(rx_bit9), int'(e.bit9));
                chk(e.tag, "fe_flag", int'(fe_flag), int'(e.fe));
            end
        end
    end

    task automatic push_exp(string tag);
        exp_t e;
        e.flag = m_flag; e.data = m_data; e.bit9 = m_b9; e.fe = m_fe; e.tag = tag;
        exp_q.push_back(e);
        ->ev_chk;
    endtask

    task automatic send(input logic [7:0] d, input logic b9, input logic stp,
                        input logic [1:0] md, input logic mp,
                        input logic rfc, input logic fec, input string tag);
        logic       acc, pend, given, bc;
        logic [7:0] bval;
        @(negedge clk);
        frm_data = d; frm_bit9 = b9; frm_stop = stp; rx_mode = md; mp_en = mp;
        rf_clr = rfc; fe_clr = fec; frm_done = 1'b1;
        given = ((d & m_mask) == (m_addr & m_mask));          // R7
        bval  = m_addr | m_mask;
        bc    = ((d & bval) == bval);                         // R8
        case (md)
            2'b00:   acc = 1'b1;
            2'b01:   acc = !mp || stp;
            default: acc = !mp || (b9 && (given || bc));
        endcase
        pend = m_flag && !rfc;
        @(posedge clk);
        if (fec) m_fe = 1'b0;
        if (md != 2'b00 && !stp) m_fe = 1'b1;
        if (rfc) m_flag = 1'b0;
        if (acc && !pend) begin
            m_flag = 1'b1;
            m_data = d;
            if (md[1]) m_b9 = b9;
            else if (md == 2'b01) m_b9 = stp;
        end
        #1;
        frm_done = 1'b0; rf_clr = 1'b0; fe_clr = 1'b0;
        push_exp(tag);
        #0;
    endtask

    task automatic clear(input logic rfc, input logic fec, input string tag);
        @(negedge clk);
        rf_clr = rfc; fe_clr = fec;
        @(posedge clk);
        if (rfc) m_flag = 1'b0;
        if (fec) m_fe = 1'b0;
        #1;
        rf_clr = 1'b0; fe_clr = 1'b0;
        push_exp(tag);
        #0;
    endtask

    task automatic wr_reg(input logic is_mask, input logic [7:0] v);
        @(negedge clk);
        wr_data = v; addr_we = !is_mask; mask_we = is_mask;
        @(posedge clk);
        if (is_mask) m_mask = v; else m_addr = v;
        #1;
        addr_we = 1'b0; mask_we = 1'b0;
    endtask

    initial begin
        #(20000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        push_exp("R1_reset");
        #0;
        @(negedge clk);
        chk("R11", "view_mode", int'(mode_hi_view), 0);

        // R1: reset registers accept any address frame
        send(8'h5A, 1, 1, 2'b10, 1, 0, 0, "R1_zero_mask_accepts");
        clear(1, 0, "R13_clear");

        // R12 + R7: program address/mask
        wr_reg(0, 8'h35);
        wr_reg(1, 8'hF0);
        send(8'h3C, 1, 1, 2'b10, 1, 0, 0, "R7_given_hit");
        clear(1, 0, "R7_clear");
        send(8'h4C, 1, 1, 2'b11, 1, 0, 0, "R7_given_miss");
        send(8'hFF, 1, 1, 2'b10, 1, 0, 0, "R8_bcast_all_ones");
        clear(1, 0, "R8_clear");
        send(8'hF7, 1, 1, 2'b11, 1, 0, 0, "R8_bcast_dontcare");
        clear(1, 0, "R8_clear2");
        send(8'hF4, 1, 1, 2'b11, 1, 0, 0, "R8_bcast_miss");

        // R6: data frame dropped under filtering
        send(8'h3C, 0, 1, 2'b10, 1, 0, 0, "R6_bit9_zero");

        // R5: no filtering in 9-bit modes
        send(8'h11, 0, 1, 2'b11, 0, 0, 0, "R5_take_b9_0");
        clear(1, 0, "R5_clear");
        send(8'h22, 1, 1, 2'b10, 0, 0, 0, "R5_take_b9_1");
        clear(1, 0, "R5_clear2");

        // R4 / R10 / R11: mode 1 bad stop under filtering
        send(8'h66, 0, 0, 2'b01, 1, 0, 0, "R4_bad_stop_drop");
        @(negedge clk);
        fe_view = 1'b1;
        #1 chk("R11", "view_fe", int'(mode_hi_view), 1);
        fe_view = 1'b0; rx_mode = 2'b00;
        #1 chk("R11", "view_mode_lo", int'(mode_hi_view), 0);
        clear(0, 1, "R10_fe_clear");
        send(8'h67, 0, 1, 2'b01, 1, 0, 0, "R4_good_stop");
        clear(1, 0, "R4_clear");

        // R3: mode 1 unfiltered takes stop into bit9
        send(8'h77, 1, 0, 2'b01, 0, 0, 0, "R3_bad_stop_take");
        clear(1, 1, "R3_clear");

        // R2: shift mode ignores filter, bit9 and stop
        send(8'h99, 1, 0, 2'b00, 1, 0, 0, "R2_shift_take");

        // R9: pending frame blocks; same-cycle clear lets through
        send(8'hAB, 1, 1, 2'b00, 0, 0, 0, "R9_blocked");
        send(8'hCD, 1, 1, 2'b10, 0, 1, 0, "R9_clear_same_cycle");

        // R10: set wins over simultaneous clear; mode 0 never sets
        send(8'h01, 1, 0, 2'b11, 0, 1, 0, "R10_set");
        send(8'h02, 1, 0, 2'b10, 0, 1, 1, "R10_set_over_clear");
        clear(1, 1, "R10_clear");
        send(8'h03, 0, 0, 2'b00, 0, 0, 0, "R10_shift_no_fe");

        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule